// File: doc/BRIEF.md
# Reservation Monitor for Linked Loads and Conditional Stores

This block places a small shared word memory behind two requesters and gives them the primitives needed to build locks: plain load and store, a linked load that remembers the address it read, a conditional store that only lands if nobody else wrote that word in the meantime, and a one-step test-and-set. Each requester raises a valid signal with an operation code, a word address and write data. It keeps that request steady until its done pulse arrives. The result word comes with the done pulse.

Requests are served one per cycle. When both requesters compete, priority alternates between them. Each operation reads, decides and writes within its grant cycle, so no other access can fall between the read and the write of an atomic operation. Each requester owns one reservation slot, holding a valid bit and an address. Every write to a word, from either side, wipes every reservation on that word. The memory and all reservations start cleared after reset.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, all memory words read 0, every done output is low, every result output is 0, and no requester holds a reservation.
- R2: Operation codes are 0 load, 1 store, 2 linked load, 3 conditional store and 4 test-and-set. Codes 5 to 7 act as loads. A load returns the addressed word and a store writes the write data to it. The done pulse for a request comes in the cycle after its grant, and the result holds until that requester's next completion.
- R3: A linked load returns the addressed word and records a reservation for that requester on that address.
- R4: A conditional store whose requester holds a reservation on the same address writes its data and returns 1.
- R5: A write to a word by any requester clears every reservation on that word. The writes that count are a store, a successful conditional store, and a test-and-set that wrote. A conditional store that relied on a cleared reservation returns 0 and leaves memory unchanged.
- R6: A conditional store returns 0 and writes nothing when its requester holds no reservation, or holds one for a different address.
- R7: A conditional store drops its requester's reservation whether it succeeds or fails, so a second conditional store without a new linked load fails.
- R8: Test-and-set returns the old word. If that word was 0, it writes 1 in the same cycle. Otherwise the word stays as it was. A returned 0 therefore means the lock was taken; 0 is free and 1 is held.
- R9: When both requesters are eligible in the same cycle, one is served per cycle with alternating priority, and requester 0 wins the first contest after reset.
- R10: A requester is not granted in a cycle where its own done output is high. A request held valid continuously completes at most every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_op | input | NREQ*3 | Operation code per requester |
| req_addr | input | NREQ*ADDR_W | Word address per requester |
| req_wdata | input | NREQ*DATA_W | Write data per requester |
| rsp_done | output | NREQ | One-cycle completion pulse per requester |
| rsp_rdata | output | NREQ*DATA_W | Result word per requester |

## Verification
The arbitration decision and the reservation clearing can land in the same cycle. This happens when both requesters send a conditional store to one word that both have linked. The bench arranges this by having each requester do a linked load on the same address and then raising both conditional stores on the same clock edge. The round-robin state then decides which one is granted first. The outcome is correct if the expected winner returns 1, the other returns 0 one cycle later, and a following load shows only the winner's data. The same contest is also run with test-and-set, and the second requester then reads back the lock as already held.

// File: rtl/llsc_pkg.sv
// Package: operation codes and shared widths for the reservation monitor.
// Assumes a 3-bit operation field on every request port.
package llsc_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_TAS   = 3'd4
    } op_e;
endpackage

// File: rtl/rr_pick.sv
// Round-robin picker: grants at most one of N requests per cycle, starting
// the search just after the last winner. Assumes requests are already
// masked for eligibility. After reset requester 0 has the highest priority.
module rr_pick #(
    parameter int N = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;

    // Search from last winner + 1 and stop at the first request.
    always_comb begin
        logic found;
        int   idx;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = IDX_W'(idx);
                found    = 1'b1;
            end
        end
    end

    // Remember the latest winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(N - 1);
        else if (|req)
            last_q <= gnt_idx;
    end
endmodule

// File: rtl/resv_table.sv
// Reservation table: one valid/address slot per requester. A write clears
// every slot on the written address. The owner's slot is set by a linked
// load or cleared by a conditional store. Assumes only one operation per
// cycle, so a set and a write never coincide.
module resv_table #(
    parameter int N      = 2,
    parameter int ADDR_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic                   clr_own_en,
    input  logic [IDX_W-1:0]       own_idx,
    input  logic [ADDR_W-1:0]      own_addr,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    output logic [N-1:0]           rv,
    output logic [N-1:0][ADDR_W-1:0] ra
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic mine;
        assign mine = (own_idx == IDX_W'(i));

        // Update slot i: a write wipe or the owner's clear takes priority over a set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv[i] <= 1'b0;
                ra[i] <= '0;
            end else if ((wr_en && rv[i] && ra[i] == wr_addr) || (clr_own_en && mine)) begin
                rv[i] <= 1'b0;
            end else if (set_en && mine) begin
                rv[i] <= 1'b1;
                ra[i] <= own_addr;
            end
        end
    end
endmodule

// File: rtl/word_mem.sv
// Word memory: asynchronous read, one synchronous write port, and a
// synchronous clear to zero on reset. Assumes a small depth (register array).
module word_mem #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Combinational read of the addressed word.
    assign rd_data = mem_q[rd_addr];

    // Clear on reset, otherwise apply the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
// Reservation monitor top: arbitrates NREQ requesters onto a shared word
// memory and executes load, store, linked load, conditional store and
// test-and-set. Each operation finishes inside its grant cycle. Assumes
// requesters hold their request until their done pulse arrives.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NREQ   = 2,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int IDX_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREQ-1:0]          req_valid,
    input  logic [NREQ*OP_W-1:0]     req_op,
    input  logic [NREQ*ADDR_W-1:0]   req_addr,
    input  logic [NREQ*DATA_W-1:0]   req_wdata,
    output logic [NREQ-1:0]          rsp_done,
    output logic [NREQ*DATA_W-1:0]   rsp_rdata
);
    logic [NREQ-1:0][OP_W-1:0]   op_a;
    logic [NREQ-1:0][ADDR_W-1:0] addr_a;
    logic [NREQ-1:0][DATA_W-1:0] wdata_a;

    for (genvar i = 0; i < NREQ; i++) begin : g_unpack
        assign op_a[i]    = req_op[i*OP_W +: OP_W];
        assign addr_a[i]  = req_addr[i*ADDR_W +: ADDR_W];
        assign wdata_a[i] = req_wdata[i*DATA_W +: DATA_W];
    end

    logic [NREQ-1:0] elig, gnt;
    logic [IDX_W-1:0] gidx;
    logic any_gnt;

    assign elig    = req_valid & ~rsp_done;
    assign any_gnt = |gnt;

    rr_pick #(.N(NREQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(elig), .gnt(gnt), .gnt_idx(gidx)
    );

    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata, old_word;
    op_e               sel_op;

    assign sel_addr  = addr_a[gidx];
    assign sel_wdata = wdata_a[gidx];
    assign sel_op    = op_e'(op_a[gidx]);

    logic              wr_en, set_en, clr_own, sc_ok;
    logic [DATA_W-1:0] wr_data, result;
    logic [NREQ-1:0]   rv;
    logic [NREQ-1:0][ADDR_W-1:0] ra;

    word_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(sel_addr), .rd_data(old_word),
        .wr_en(wr_en), .wr_addr(sel_addr), .wr_data(wr_data)
    );

    resv_table #(.N(NREQ), .ADDR_W(ADDR_W)) u_resv (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_own_en(clr_own),
        .own_idx(gidx), .own_addr(sel_addr), .wr_en(wr_en), .wr_addr(sel_addr),
        .rv(rv), .ra(ra)
    );

    assign sc_ok = rv[gidx] && (ra[gidx] == sel_addr);

    // Decode the granted operation into write, reservation and result controls.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = sel_wdata;
        set_en  = 1'b0;
        clr_own = 1'b0;
        result  = old_word;
        case (sel_op)
            OP_STORE: wr_en = any_gnt;
            OP_LL:    set_en = any_gnt;
            OP_SC: begin
                clr_own = any_gnt;
                wr_en   = any_gnt && sc_ok;
                result  = DATA_W'(sc_ok);
            end
            OP_TAS: begin
                wr_en   = any_gnt && (old_word == '0);
                wr_data = DATA_W'(1);
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < NREQ; i++) begin : g_rsp
        // Register the completion pulse and capture the result for requester i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_done[i]                   <= 1'b0;
                rsp_rdata[i*DATA_W +: DATA_W] <= '0;
            end else begin
                rsp_done[i] <= gnt[i];
                if (gnt[i]) rsp_rdata[i*DATA_W +: DATA_W] <= result;
            end
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Checker for the reservation monitor, watching only the top-level ports.
// Bound to every instance of llsc_monitor.
module llsc_monitor_chk #(
    parameter int NREQ   = 2,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NREQ-1:0]        req_valid,
    input logic [NREQ*3-1:0]      req_op,
    input logic [NREQ-1:0]        rsp_done,
    input logic [NREQ*DATA_W-1:0] rsp_rdata
);
    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (rsp_done == '0)); // R1

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_done[i] |-> $past(req_valid[i])); // R2

        AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_done[i] |=> !rsp_done[i]); // R10

        AST_SC_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_done[i] && $past(req_op[i*3 +: 3]) == 3'd3)
                |-> (rsp_rdata[i*DATA_W +: DATA_W] <= 1)); // R4
    end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
    localparam int NREQ = 2, DEPTH = 16, DW = 32, AW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NREQ-1:0]    req_valid = '0;
    logic [NREQ*3-1:0]  req_op    = '0;
    logic [NREQ*AW-1:0] req_addr  = '0;
    logic [NREQ*DW-1:0] req_wdata = '0;
    logic [NREQ-1:0]    rsp_done;
    logic [NREQ*DW-1:0] rsp_rdata;

    int n_tests = 0, n_fail = 0, lastg = 1;

    always #10 clk = ~clk;

    llsc_monitor #(.NREQ(NREQ), .DEPTH(DEPTH), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input int r, input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_op[r*3 +: 3]     = op;
        req_addr[r*AW +: AW] = a;
        req_wdata[r*DW +: DW] = d;
        req_valid[r]         = 1'b1;
    endtask

    task automatic do_op(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] q);
        @(negedge clk);
        setup(r, op, a, d);
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (rsp_done[r]) break;
        end
        check("R2 done seen", {31'd0, rsp_done[r]}, 32'd1);
        q = rsp_rdata[r*DW +: DW];
        req_valid[r] = 1'b0;
        lastg = r;
    endtask

    task automatic t_reset;
        logic [DW-1:0] q;
        check("R1 done low", {30'd0, rsp_done}, 32'd0);
        check("R1 rdata zero", rsp_rdata[DW-1:0] | rsp_rdata[2*DW-1:DW], 32'd0);
        do_op(0, 3'd0, 4'd5, 0, q);
        check("R1 mem zero", q, 32'd0);
        do_op(1, 3'd3, 4'd7, 32'h55, q);
        check("R1 no reservation", q, 32'd0);
    endtask

    task automatic t_load_store;
        logic [DW-1:0] q;
        do_op(0, 3'd1, 4'd3, 32'hA5A5_0001, q);
        do_op(1, 3'd0, 4'd3, 0, q);
        check("R2 load after store", q, 32'hA5A5_0001);
        do_op(1, 3'd6, 4'd3, 0, q);
        check("R2 code 6 acts as load", q, 32'hA5A5_0001);
    endtask

    task automatic t_llsc;
        logic [DW-1:0] q;
        do_op(0, 3'd1, 4'd4, 32'd77, q);
        do_op(0, 3'd2, 4'd4, 0, q);
        check("R3 linked load value", q, 32'd77);
        do_op(0, 3'd3, 4'd4, 32'd99, q);
        check("R4 sc success flag", q, 32'd1);
        do_op(1, 3'd0, 4'd4, 0, q);
        check("R4 sc wrote", q, 32'd99);
        do_op(0, 3'd3, 4'd4, 32'd5, q);
        check("R7 second sc fails", q, 32'd0);
        do_op(1, 3'd0, 4'd4, 0, q);
        check("R7 second sc no write", q, 32'd99);
    endtask

    task automatic t_intervene;
        logic [DW-1:0] q;
        do_op(0, 3'd2, 4'd6, 0, q);
        do_op(1, 3'd1, 4'd6, 32'd11, q);
        do_op(0, 3'd3, 4'd6, 32'd22, q);
        check("R5 sc after foreign store", q, 32'd0);
        do_op(0, 3'd0, 4'd6, 0, q);
        check("R5 memory keeps store", q, 32'd11);
        do_op(1, 3'd2, 4'd12, 0, q);
        do_op(0, 3'd4, 4'd12, 0, q);
        do_op(1, 3'd3, 4'd12, 32'd8, q);
        check("R5 sc after foreign tas", q, 32'd0);
    endtask

    task automatic t_noresv;
        logic [DW-1:0] q;
        do_op(1, 3'd2, 4'd8, 0, q);
        do_op(1, 3'd3, 4'd9, 32'd3, q);
        check("R6 sc wrong address", q, 32'd0);
        do_op(0, 3'd0, 4'd9, 0, q);
        check("R6 no write on wrong address", q, 32'd0);
    endtask

    task automatic t_tas;
        logic [DW-1:0] q;
        do_op(0, 3'd4, 4'd10, 0, q);
        check("R8 tas free returns 0", q, 32'd0);
        do_op(1, 3'd0, 4'd10, 0, q);
        check("R8 tas set lock", q, 32'd1);
        do_op(1, 3'd1, 4'd11, 32'd7, q);
        do_op(1, 3'd4, 4'd11, 0, q);
        check("R8 tas busy returns old", q, 32'd7);
        do_op(0, 3'd0, 4'd11, 0, q);
        check("R8 tas busy no write", q, 32'd7);
    endtask

    // Raise both requests on one edge; returns the results and checks the order.
    task automatic both(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        output logic [DW-1:0] q0, output logic [DW-1:0] q1, output int first);
        int other;
        first = (lastg == 0) ? 1 : 0;
        other = 1 - first;
        @(negedge clk);
        setup(0, op, a, d0);
        setup(1, op, a, d1);
        @(negedge clk);
        check("R9 first winner", {30'd0, rsp_done}, 32'd1 << first);
        if (first == 0) q0 = rsp_rdata[DW-1:0]; else q1 = rsp_rdata[2*DW-1:DW];
        req_valid[first] = 1'b0;
        @(negedge clk);
        check("R9 second winner", {30'd0, rsp_done}, 32'd1 << other);
        if (other == 0) q0 = rsp_rdata[DW-1:0]; else q1 = rsp_rdata[2*DW-1:DW];
        req_valid[other] = 1'b0;
        lastg = other;
    endtask

    task automatic t_rr;
        logic [DW-1:0] q0, q1, q;
        int f;
        do_op(0, 3'd1, 4'd2, 32'd40, q);
        both(3'd0, 4'd2, 0, 0, q0, q1, f);
        check("R9 loads equal", q0 ^ q1, 32'd0);
        both(3'd0, 4'd2, 0, 0, q0, q1, f);
        check("R9 load value", q0, 32'd40);
    endtask

    task automatic t_contend;
        logic [DW-1:0] q0, q1, q;
        int f;
        do_op(0, 3'd2, 4'd13, 0, q);
        do_op(1, 3'd2, 4'd13, 0, q);
        both(3'd3, 4'd13, 32'd100, 32'd200, q0, q1, f);
        check("R5 contest winner flag", (f == 0) ? q0 : q1, 32'd1);
        check("R5 contest loser flag", (f == 0) ? q1 : q0, 32'd0);
        do_op(0, 3'd0, 4'd13, 0, q);
        check("R5 contest memory", q, (f == 0) ? 32'd100 : 32'd200);
        both(3'd4, 4'd14, 0, 0, q0, q1, f);
        check("R8 contest tas winner", (f == 0) ? q0 : q1, 32'd0);
        check("R8 contest tas loser", (f == 0) ? q1 : q0, 32'd1);
    endtask

    task automatic t_hold;
        @(negedge clk);
        setup(0, 3'd0, 4'd2, 0);
        @(negedge clk); check("R10 held 1", {31'd0, rsp_done[0]}, 32'd1);
        @(negedge clk); check("R10 held 2", {31'd0, rsp_done[0]}, 32'd0);
        @(negedge clk); check("R10 held 3", {31'd0, rsp_done[0]}, 32'd1);
        @(negedge clk); check("R10 held 4", {31'd0, rsp_done[0]}, 32'd0);
        req_valid[0] = 1'b0;
        lastg = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_store();
        t_llsc();
        t_intervene();
        t_noresv();
        t_tas();
        t_rr();
        t_contend();
        t_hold();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule